// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Sequencer

This block is the control side of a battery-free nonvolatile memory: a working SRAM array paired with a shadow array of equal size. A STORE copies the working array into the shadow, and a RECALL copies the shadow back. Software can ask for either transfer through a request strobe. When the supply returns after a real power loss, the block starts a RECALL by itself.

Supply health arrives as two digitized monitor flags. One says the supply is above the trigger level. The other says it is above the lower reset level. Whenever the supply is under the trigger level, the block raises an inhibit flag. While inhibit is high, host accesses and software requests are gated.

Transfer durations are counted in clock cycles through parameters. A transfer does not change either array until its final cycle. A transfer cut short by a supply drop therefore leaves its destination untouched.

Top module: `nvsram_seq`

## Requirements
- R1: After reset, the first cycle in which both supply flags are high starts an automatic RECALL. busy then stays high for exactly RECALL_CYC cycles.
- R2: An automatic RECALL starts when the supply rises back above the trigger level, but only if the reset-level flag has been low since the last automatic RECALL. A dip that keeps the reset-level flag high starts nothing, and the SRAM keeps its contents.
- R3: The supply counts as above the trigger level only when both flags are high. inhibit is high exactly when it is not, including when the trigger flag is high and the reset flag is low.
- R4: A software STORE has sw_req=1 and sw_op=0. It is accepted when ce is high, the block is idle and inhibit is low. busy then stays high for exactly STORE_CYC cycles, and the shadow receives the whole SRAM.
- R5: A software RECALL has sw_req=1 and sw_op=1. It is accepted under the same conditions as R4. busy then stays high for exactly RECALL_CYC cycles, and the SRAM receives the whole shadow.
- R6: While inhibit is high, software requests are ignored and busy stays low.
- R7: If the supply falls below the trigger level during a transfer, the transfer aborts and busy is low in the next cycle. An aborted STORE leaves the previous shadow contents intact.
- R8: While busy is high, host writes are ignored, host reads return rdata_valid=0, and software requests are ignored and not queued.
- R9: standby is high exactly when ce is low and busy is low. Lowering ce during a transfer does not give standby until the transfer ends.
- R10: A host access takes place when ce is high, busy is low and inhibit is low. A write with wr_en=1 stores wdata at addr. A read with wr_en=0 returns the word on rdata, with rdata_valid high, one cycle later. When inhibit is high, host writes are ignored and reads return rdata_valid=0.
- R11: If an automatic RECALL and a software request fall in the same cycle, the RECALL wins and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vtrig_ok | input | 1 | Supply is above the trigger level |
| vrst_ok | input | 1 | Supply is above the reset level |
| ce | input | 1 | Chip enable |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| sw_req | input | 1 | Software transfer request strobe |
| sw_op | input | 1 | 0 = STORE, 1 = RECALL |
| rdata | output | DATA_W | Read data, 0 when not valid |
| rdata_valid | output | 1 | rdata holds the result of the previous cycle's read |
| busy | output | 1 | A transfer is in progress |
| standby | output | 1 | Chip disabled and no transfer running |
| inhibit | output | 1 | Supply below trigger level; host bus gated |

## Verification
An automatic power-up RECALL and a software STORE request can land in the same cycle. The bench provokes this by holding a STORE request in the very cycle that both supply flags come back after a drop below the reset level. The bench judges the outcome in two ways. The busy pulse must last RECALL_CYC cycles rather than STORE_CYC. A word written before the brown-out must then read back as the older shadow value, which shows that no STORE overwrote the shadow. A second overlap is a host write or software request made during a transfer; the bench checks it by reading the word back afterwards and by confirming that busy does not rise again.

// File: rtl/nvsram_seq.sv
module nvsram_seq #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int STORE_CYC  = 20,
  parameter int RECALL_CYC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vtrig_ok,
  input  logic              vrst_ok,
  input  logic              ce,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sw_req,
  input  logic              sw_op,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic              busy,
  output logic              standby,
  output logic              inhibit
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXC  = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CW    = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_STORE, S_RECALL} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic              trig_q, armed;
  logic [DATA_W-1:0] sram   [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];

  logic trig_ok, pwr_rise, host_ok, sw_go, done, done_ok;

  assign trig_ok  = vtrig_ok & vrst_ok;
  assign inhibit  = ~trig_ok;
  assign busy     = (st != S_IDLE);
  assign standby  = ~ce & ~busy;
  assign pwr_rise = trig_ok & ~trig_q & armed;
  assign host_ok  = ce & ~busy & trig_ok;
  assign sw_go    = sw_req & host_ok & ~pwr_rise;
  assign done     = busy & (cnt == '0);
  assign done_ok  = done & trig_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      trig_q <= 1'b0;
      armed  <= 1'b1;
    end else begin
      trig_q <= trig_ok;
      if (!vrst_ok)      armed <= 1'b1;
      else if (pwr_rise) armed <= 1'b0;

      if (busy && !trig_ok) st <= S_IDLE;
      else if (done)        st <= S_IDLE;
      else if (busy)        cnt <= cnt - 1'b1;
      else if (pwr_rise) begin
        st  <= S_RECALL;
        cnt <= CW'(RECALL_CYC - 1);
      end else if (sw_go) begin
        st  <= sw_op ? S_RECALL : S_STORE;
        cnt <= sw_op ? CW'(RECALL_CYC - 1) : CW'(STORE_CYC - 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (done_ok && st == S_RECALL) begin
      for (int i = 0; i < DEPTH; i++) sram[i] <= shadow[i];
    end else if (host_ok && wr_en) begin
      sram[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (done_ok && st == S_STORE) begin
      for (int i = 0; i < DEPTH; i++) shadow[i] <= sram[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_valid <= 1'b0;
      rdata       <= '0;
    end else begin
      rdata_valid <= host_ok & ~wr_en;
      rdata       <= (host_ok & ~wr_en) ? sram[addr] : '0;
    end
  end
endmodule

// File: rtl/nvsram_seq_chk.sv
module nvsram_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic vtrig_ok,
  input logic vrst_ok,
  input logic ce,
  input logic wr_en,
  input logic rdata_valid,
  input logic busy,
  input logic standby,
  input logic inhibit
);
  a_r7_abort_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !vtrig_ok) |=> !busy);

  a_r6_no_start_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !busy) |=> !busy);

  a_r8_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rdata_valid);

  a_r9_standby_idle: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (!busy && !ce));

  a_r10_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !wr_en && !busy && vtrig_ok && vrst_ok) |=> rdata_valid);

  a_r3_reset_flag_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    !vrst_ok |=> !rdata_valid);
endmodule

bind nvsram_seq nvsram_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vtrig_ok(vtrig_ok), .vrst_ok(vrst_ok),
  .ce(ce), .wr_en(wr_en), .rdata_valid(rdata_valid), .busy(busy),
  .standby(standby), .inhibit(inhibit)
);

// File: tb/nvsram_seq_test.sv
module nvsram_seq_test;
  localparam int AW = 4, DW = 8, SC = 20, RC = 12;

  logic clk = 0, rst_n = 0, vtrig_ok = 1, vrst_ok = 1, ce = 0, wr_en = 0;
  logic sw_req = 0, sw_op = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_valid, busy, standby, inhibit;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  nvsram_seq #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYC(SC), .RECALL_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .vtrig_ok(vtrig_ok), .vrst_ok(vrst_ok), .ce(ce),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .sw_req(sw_req), .sw_op(sw_op),
    .rdata(rdata), .rdata_valid(rdata_valid), .busy(busy), .standby(standby),
    .inhibit(inhibit));

  localparam logic [11:0] VEC [8] = '{12'h0_A1, 12'h3_5C, 12'h7_00, 12'hF_FF,
                                     12'h1_96, 12'h8_2B, 12'hC_E4, 12'h5_17};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce = 1; wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce = 1; wr_en = 0; addr = a;
    @(negedge clk);
    chk({tag, " valid"}, rdata_valid, 1);
    chk({tag, " data"}, rdata, d);
  endtask

  task automatic sw(input logic op);
    ce = 1; sw_req = 1; sw_op = op;
    @(negedge clk);
    sw_req = 0;
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R9 reset standby", standby, 1);
    chk("R3 reset inhibit", inhibit, 0);
    chk("R1 reset busy", busy, 0);
    rst_n = 1;
    @(negedge clk);
    count_busy(n);
    chk("R1 initial recall length", n, RC);

    ce = 1;
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][11:8], VEC[i][7:0]);
      rd("R10 vector readback", VEC[i][11:8], VEC[i][7:0]);
    end

    sw(1'b0);
    count_busy(n);
    chk("R4 store length", n, SC);
    wr(VEC[0][11:8], 8'h5A);
    rd("R10 overwrite", VEC[0][11:8], 8'h5A);
    sw(1'b1);
    count_busy(n);
    chk("R5 recall length", n, RC);
    rd("R5 recalled word", VEC[0][11:8], VEC[0][7:0]);
    rd("R4 stored word", VEC[3][11:8], VEC[3][7:0]);

    sw(1'b0);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 2) begin
        ce = 1; wr_en = 1; addr = VEC[0][11:8]; wdata = 8'hEE; sw_req = 1; sw_op = 1;
      end else if (n == 3) begin
        wr_en = 0; sw_req = 0;
      end else if (n == 4) begin
        chk("R8 read while busy", rdata_valid, 0);
        ce = 0;
      end else if (n == 5) begin
        chk("R9 no standby while busy", standby, 0);
      end
      @(negedge clk);
    end
    chk("R8 store not extended", n, SC);
    chk("R9 standby after transfer", standby, 1);
    @(negedge clk);
    chk("R8 request not queued", busy, 0);
    rd("R8 write ignored while busy", VEC[0][11:8], VEC[0][7:0]);

    wr(VEC[0][11:8], 8'h33);
    sw(1'b0);
    repeat (5) @(negedge clk);
    vtrig_ok = 0;
    @(negedge clk);
    chk("R7 abort clears busy", busy, 0);
    chk("R3 inhibit on trigger drop", inhibit, 1);
    sw(1'b0);
    chk("R6 store ignored when inhibited", busy, 0);
    ce = 1; wr_en = 0;
    @(negedge clk);
    chk("R10 read gated when inhibited", rdata_valid, 0);
    vtrig_ok = 1;
    repeat (3) @(negedge clk);
    chk("R2 shallow dip no recall", busy, 0);
    rd("R2 sram kept after dip", VEC[0][11:8], 8'h33);
    sw(1'b1);
    count_busy(n);
    rd("R7 shadow intact after abort", VEC[0][11:8], VEC[0][7:0]);

    wr(VEC[0][11:8], 8'h44);
    vrst_ok = 0;
    @(negedge clk);
    chk("R3 reset flag low inhibits", inhibit, 1);
    vtrig_ok = 0;
    repeat (3) @(negedge clk);
    vtrig_ok = 1; vrst_ok = 1; ce = 1; sw_req = 1; sw_op = 0;
    @(negedge clk);
    sw_req = 0;
    count_busy(n);
    chk("R11 recall wins over store", n, RC);
    rd("R2 recall after deep drop", VEC[0][11:8], VEC[0][7:0]);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule